// File: doc/BRIEF.md
# Serial Memory Block Write-Protect Controller

This block sits behind the bit-level two-wire slave of a 512-byte module-configuration memory. It receives decoded bus events: a start or repeated start, a stop, each byte the master sends, and the master's acknowledge slot after each byte read out. From these it decides whether the slave acknowledges each byte. It also tracks the protection state of the four 128-byte blocks, the selected 256-byte page and the byte address counter.

The block issues write strobes into a page buffer and read strobes towards the array. It also signals the start of the self-timed internal write cycle and reports while that cycle runs. All status reaches the master only through Ack and NoAck answers. The nonvolatile array, the page buffer and the bit shifter lie outside this block.

A select byte carries a four-bit type code in bits 7:4, three address bits in 3:1 and the read flag in bit 0. The memory type and the sensor type respond only to their own address. The protection-and-page type is global and carries its command in bits 3:0.

Top module: `spd_wp_ctrl`

## Requirements
- R1: `ack_valid` pulses in the cycle after each `ev_byte`, and `ack` is 1 only for an acknowledge. A select byte of type 1010 (memory) or 0011 (sensor) is acknowledged only when bits 3:1 equal `sel_addr`. Type 0110 ignores bits 3:1, and any other type gets NoAck.
- R2: Under type 0110, bits 3:0 encode the commands. Set-protect is 0010, 1000, 1010, 0000 for blocks 0 to 3. Clear-all is 0110. Protect-status is 0011, 1001, 1011, 0001 for blocks 0 to 3. Page select is 1100 (page 0) or 1110 (page 1), and page query is 1101. Set-protect and clear-all are acknowledged only while `hv_pin` is 1, and they take effect at a stop that directly follows an acknowledged data byte.
- R3: Set-protect for a block that is already protected answers NoAck to the command, address and data bytes, and the following stop starts no write cycle.
- R4: Protect-status answers NoAck when the block is protected. Otherwise it answers Ack to the command and NoAck to every later byte.
- R5: The page bit resets to 0 and is set by the page-select commands. Page query answers Ack for page 0 and NoAck for page 1. The page forms bit 8 of every memory address.
- R6: The block index is {page, address bit 7}. A data byte aimed at a protected block gets NoAck, produces no `mem_we`, and leaves the address counter unchanged.
- R7: Each acknowledged data byte pulses `mem_we` with `mem_addr` = {page, counter} and `mem_wdata` = the byte. The counter then advances within its aligned 16-byte group, keeping address bits 7:4.
- R8: A stop right after an acknowledged data byte starts a write cycle. A stop at any other point starts none. A memory write also pulses `mem_commit`, and `busy` stays high for exactly `WR_CYCLES` cycles.
- R9: While `busy` is high, select bytes of types 1010 and 0110 get NoAck, while sensor selects are still acknowledged.
- R10: A read select and each master Ack after a read byte pulse `rd_strobe` with `rd_addr` = {page, counter} and advance the counter, wrapping 0xFF to 0x00. A master NoAck returns the block to idle until the next start.
- R11: After reset `ack_valid`, `ack`, `mem_we`, `mem_commit`, `rd_strobe` and `busy` are 0, no block is protected and the page is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_addr | input | 3 | Local select address |
| hv_pin | input | 1 | High voltage detected on address pin 0 |
| ev_start | input | 1 | Start or repeated start seen |
| ev_stop | input | 1 | Stop seen |
| ev_byte | input | 1 | Byte from master received |
| byte_in | input | 8 | Received byte |
| ev_rdone | input | 1 | Master acknowledge slot after a read byte |
| mst_ack | input | 1 | 1 when the master acknowledged |
| ack_valid | output | 1 | Answer for the last byte is present |
| ack | output | 1 | 1 = Ack, 0 = NoAck |
| mem_we | output | 1 | Page buffer write strobe |
| mem_addr | output | 9 | Page buffer write address |
| mem_wdata | output | 8 | Page buffer write data |
| mem_commit | output | 1 | Internal write cycle starts for memory data |
| rd_strobe | output | 1 | Array read request |
| rd_addr | output | 9 | Array read address |
| busy | output | 1 | Internal write cycle running |

## Verification
The assertions check on every cycle that the timer counts down without a gap and that no write strobe reaches a protected block or falls inside a write cycle. They also check that an acknowledge never appears without its valid pulse and that the protection bits move only on a request. The bench scenarios are needed to show the command decoding and answers, and the group wrap of page writes. They also cover the unchanged counter after a refused byte (seen through the next read address), the exact length of the busy window, and the sequential-read wrap and termination.

// File: rtl/spd_wp_pkg.sv
// Shared types for the write-protect controller: controller states and
// the classification of a select byte. Assumes a 4-bit type code.
package spd_wp_pkg;
    localparam logic [3:0] TYPE_MEM = 4'b1010;
    localparam logic [3:0] TYPE_TS  = 4'b0011;
    localparam logic [3:0] TYPE_WP  = 4'b0110;

    typedef enum logic [3:0] {
        S_IDLE, S_SEL, S_MADDR, S_MDATA, S_MRD, S_TS, S_CADDR, S_CDATA, S_NACK
    } wp_state_e;

    typedef enum logic [2:0] {
        K_NONE, K_MEM, K_TS, K_SWP, K_CWP, K_RPS, K_SPA, K_RPA
    } sel_kind_e;

    typedef struct packed {
        sel_kind_e  kind;
        logic [1:0] blk;
        logic       pg;
        logic       rd;
    } sel_info_t;
endpackage

// File: rtl/spd_sel_decode.sv
// Classifies a select byte. Memory and sensor types must match the local
// address in bits 3:1; the protect/page type decodes bits 3:0 as a command.
// Purely combinational; assumes the byte is stable while used.
module spd_sel_decode
    import spd_wp_pkg::*;
(
    input  logic [7:0] byte_in,
    input  logic [2:0] sel_addr,
    output sel_info_t  info
);
    // Map the type nibble and command bits to a classified request.
    always_comb begin
        info      = '0;
        info.kind = K_NONE;
        info.rd   = byte_in[0];
        if (byte_in[7:4] == TYPE_MEM && byte_in[3:1] == sel_addr) begin
            info.kind = K_MEM;
        end else if (byte_in[7:4] == TYPE_TS && byte_in[3:1] == sel_addr) begin
            info.kind = K_TS;
        end else if (byte_in[7:4] == TYPE_WP) begin
            case (byte_in[3:0])
                4'b0010: begin info.kind = K_SWP; info.blk = 2'd0; end
                4'b1000: begin info.kind = K_SWP; info.blk = 2'd1; end
                4'b1010: begin info.kind = K_SWP; info.blk = 2'd2; end
                4'b0000: begin info.kind = K_SWP; info.blk = 2'd3; end
                4'b0110: info.kind = K_CWP;
                4'b0011: begin info.kind = K_RPS; info.blk = 2'd0; end
                4'b1001: begin info.kind = K_RPS; info.blk = 2'd1; end
                4'b1011: begin info.kind = K_RPS; info.blk = 2'd2; end
                4'b0001: begin info.kind = K_RPS; info.blk = 2'd3; end
                4'b1100: begin info.kind = K_SPA; info.pg = 1'b0; end
                4'b1110: begin info.kind = K_SPA; info.pg = 1'b1; end
                4'b1101: info.kind = K_RPA;
                default: info.kind = K_NONE;
            endcase
        end
    end
endmodule

// File: rtl/spd_prot_regs.sv
// Holds one protection bit per block, standing in for nonvolatile state.
// A set request marks one block; a clear request wipes all of them.
module spd_prot_regs #(
    parameter int N_BLK = 4,
    localparam int BW = $clog2(N_BLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [BW-1:0]    blk,
    output logic [N_BLK-1:0] prot
);
    // Apply set or clear requests to the protection bits.
    always_ff @(posedge clk) begin
        if (!rst_n)      prot <= '0;
        else if (clr_en) prot <= '0;
        else if (set_en) prot[blk] <= 1'b1;
    end

    AST_PROT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr_en) |=> $stable(prot)); // R3
endmodule

// File: rtl/spd_busy_timer.sv
// Self-timed write cycle: loaded on start, counts down, busy while nonzero.
module spd_busy_timer #(
    parameter int WR_CYCLES = 500000,
    localparam int CW = $clog2(WR_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    logic [CW-1:0] cnt;

    // Load the duration on start and count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= CW'(WR_CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    AST_BUSY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> (cnt == $past(cnt) - 1'b1)); // R8
    AST_BUSY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy); // R8
endmodule

// File: rtl/spd_wp_ctrl.sv
// Write-protect and acknowledge controller for a two-page serial memory.
// Consumes decoded bus events (one-cycle pulses, at most one per cycle)
// and answers each received byte one cycle later. Assumes the bit shifter
// drives the acknowledge from ack/ack_valid and reads array data itself.
module spd_wp_ctrl
    import spd_wp_pkg::*;
#(
    parameter int WR_CYCLES = 500000,
    parameter int ADDR_W    = 8,
    parameter int PAGE_WR   = 16,
    localparam int MEM_AW   = ADDR_W + 1,
    localparam int GRP_W    = $clog2(PAGE_WR),
    localparam int N_BLK    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        sel_addr,
    input  logic              hv_pin,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              ev_byte,
    input  logic [7:0]        byte_in,
    input  logic              ev_rdone,
    input  logic              mst_ack,
    output logic              ack_valid,
    output logic              ack,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_commit,
    output logic              rd_strobe,
    output logic [MEM_AW-1:0] rd_addr,
    output logic              busy
);
    wp_state_e          st;
    sel_info_t          dec;
    logic [N_BLK-1:0]   prot;
    logic               page;
    logic [ADDR_W-1:0]  cnt;
    logic               data_last;
    logic               cmd_clr;
    logic [1:0]         cmd_blk;
    logic               wr_go, prot_set, prot_clr;

    spd_sel_decode u_dec (.byte_in(byte_in), .sel_addr(sel_addr), .info(dec));

    // A stop directly after an acknowledged data byte launches the cycle.
    always_comb begin
        wr_go    = ev_stop && !ev_start && data_last && (st == S_MDATA || st == S_CDATA);
        prot_set = wr_go && (st == S_CDATA) && !cmd_clr;
        prot_clr = wr_go && (st == S_CDATA) && cmd_clr;
    end

    spd_prot_regs #(.N_BLK(N_BLK)) u_prot (
        .clk(clk), .rst_n(rst_n), .set_en(prot_set), .clr_en(prot_clr),
        .blk(cmd_blk), .prot(prot));

    spd_busy_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(wr_go), .busy(busy));

    // Main sequencer: answers bytes, steps the counter, issues strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; page <= 1'b0; cnt <= '0; data_last <= 1'b0;
            cmd_clr <= 1'b0; cmd_blk <= '0;
            ack_valid <= 1'b0; ack <= 1'b0; mem_we <= 1'b0; mem_commit <= 1'b0;
            mem_addr <= '0; mem_wdata <= '0; rd_strobe <= 1'b0; rd_addr <= '0;
        end else begin
            ack_valid <= 1'b0; ack <= 1'b0; mem_we <= 1'b0;
            mem_commit <= 1'b0; rd_strobe <= 1'b0;
            if (ev_start) begin
                st <= S_SEL; data_last <= 1'b0;
            end else if (ev_stop) begin
                mem_commit <= wr_go && (st == S_MDATA);
                st <= S_IDLE; data_last <= 1'b0;
            end else if (ev_byte) begin
                ack_valid <= 1'b1; data_last <= 1'b0;
                case (st)
                    S_SEL: begin
                        st <= S_NACK;
                        case (dec.kind)
                            K_MEM: if (!busy) begin
                                ack <= 1'b1;
                                if (dec.rd) begin
                                    st <= S_MRD; rd_strobe <= 1'b1;
                                    rd_addr <= {page, cnt}; cnt <= cnt + 1'b1;
                                end else st <= S_MADDR;
                            end
                            K_TS: begin ack <= 1'b1; st <= S_TS; end
                            K_SWP: if (!busy && hv_pin && !prot[dec.blk]) begin
                                ack <= 1'b1; st <= S_CADDR;
                                cmd_clr <= 1'b0; cmd_blk <= dec.blk;
                            end
                            K_CWP: if (!busy && hv_pin) begin
                                ack <= 1'b1; st <= S_CADDR; cmd_clr <= 1'b1;
                            end
                            K_RPS: ack <= !busy && !prot[dec.blk];
                            K_SPA: if (!busy) begin ack <= 1'b1; page <= dec.pg; end
                            K_RPA: ack <= !busy && !page;
                            default: ;
                        endcase
                    end
                    S_MADDR: begin ack <= 1'b1; cnt <= byte_in[ADDR_W-1:0]; st <= S_MDATA; end
                    S_MDATA: if (!prot[{page, cnt[ADDR_W-1]}]) begin
                        ack <= 1'b1; data_last <= 1'b1;
                        mem_we <= 1'b1; mem_addr <= {page, cnt}; mem_wdata <= byte_in;
                        cnt <= {cnt[ADDR_W-1:GRP_W], cnt[GRP_W-1:0] + 1'b1};
                    end
                    S_CADDR: begin ack <= 1'b1; st <= S_CDATA; end
                    S_CDATA: begin ack <= 1'b1; data_last <= 1'b1; end
                    S_TS:    ack <= 1'b1;
                    default: ;
                endcase
            end else if (ev_rdone) begin
                data_last <= 1'b0;
                if (st == S_MRD) begin
                    if (mst_ack) begin
                        rd_strobe <= 1'b1; rd_addr <= {page, cnt}; cnt <= cnt + 1'b1;
                    end else st <= S_IDLE;
                end
            end
        end
    end

    AST_ACK_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> ack_valid); // R1
    AST_WE_UNPROT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !prot[{mem_addr[ADDR_W], mem_addr[ADDR_W-1]}]); // R6
    AST_WE_IDLE_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !busy); // R9
    AST_COMMIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_commit |-> busy); // R8
    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, rd_strobe, mem_commit})); // R7
endmodule

// File: tb/spd_wp_ctrl_bench.sv
module spd_wp_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WR = 40;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [2:0] sel_addr = 3'b101;
    logic hv_pin = 1'b0, ev_start = 1'b0, ev_stop = 1'b0, ev_byte = 1'b0;
    logic [7:0] byte_in = '0;
    logic ev_rdone = 1'b0, mst_ack = 1'b0;
    logic ack_valid, ack, mem_we, mem_commit, rd_strobe, busy;
    logic [8:0] mem_addr, rd_addr;
    logic [7:0] mem_wdata;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spd_wp_ctrl #(.WR_CYCLES(WR)) u_spd_wp_ctrl (
        .clk(clk), .rst_n(rst_n), .sel_addr(sel_addr), .hv_pin(hv_pin),
        .ev_start(ev_start), .ev_stop(ev_stop), .ev_byte(ev_byte), .byte_in(byte_in),
        .ev_rdone(ev_rdone), .mst_ack(mst_ack), .ack_valid(ack_valid), .ack(ack),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_commit(mem_commit), .rd_strobe(rd_strobe), .rd_addr(rd_addr), .busy(busy));

    // select byte, hv level, expected answer
    localparam logic [9:0] TBL [10] = '{
        {8'hAA, 1'b0, 1'b1},  // R1 memory, own address
        {8'hA0, 1'b0, 1'b0},  // R1 memory, other address
        {8'h3A, 1'b0, 1'b1},  // R1 sensor, own address
        {8'h36, 1'b0, 1'b0},  // R1 sensor, other address
        {8'h6C, 1'b0, 1'b1},  // R5 page 0 select
        {8'h6D, 1'b0, 1'b1},  // R5 page query on page 0
        {8'h64, 1'b0, 1'b0},  // R2 reserved command
        {8'h62, 1'b0, 1'b0},  // R2 set-protect without high voltage
        {8'h63, 1'b0, 1'b1},  // R4 status of free block
        {8'h5A, 1'b0, 1'b0}   // R1 unknown type
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); ev_start = 1'b1; @(negedge clk); ev_start = 1'b0;
    endtask
    task automatic pulse_stop();
        @(negedge clk); ev_stop = 1'b1; @(negedge clk); ev_stop = 1'b0;
    endtask
    task automatic send(input logic [7:0] b);
        @(negedge clk); ev_byte = 1'b1; byte_in = b; @(negedge clk); ev_byte = 1'b0;
    endtask
    task automatic rdone(input logic m);
        @(negedge clk); ev_rdone = 1'b1; mst_ack = m; @(negedge clk); ev_rdone = 1'b0;
    endtask
    task automatic wait_idle();
        for (int i = 0; i < WR + 5 && busy; i++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 ack_valid", ack_valid, 0);
        chk("R11 busy", busy, 0);
        chk("R11 strobes", {mem_we, mem_commit, rd_strobe}, 0);
        rst_n = 1'b1;

        for (int i = 0; i < 10; i++) begin
            hv_pin = TBL[i][1];
            pulse_start(); send(TBL[i][9:2]);
            chk("R1 table ack", {ack_valid, ack}, {1'b1, TBL[i][0]});
            pulse_stop();
        end

        // R7 page write with group wrap, R8 commit and duration
        pulse_start(); send(8'hAA); send(8'h0E);
        send(8'h11); chk("R7 we addr", {mem_we, mem_addr}, {1'b1, 9'h00E});
        chk("R7 data", mem_wdata, 8'h11);
        send(8'h22); chk("R7 addr2", mem_addr, 9'h00F);
        send(8'h33); chk("R7 group wrap", {mem_we, mem_addr}, {1'b1, 9'h000});
        pulse_stop();
        chk("R8 commit", {mem_commit, busy}, 2'b11);
        repeat (WR - 1) @(negedge clk);
        chk("R8 busy end-1", busy, 1);
        @(negedge clk);
        chk("R8 busy done", busy, 0);

        // R9 selects during write cycle
        pulse_start(); send(8'hAA); send(8'h20); send(8'h55); pulse_stop();
        pulse_start(); send(8'hAA); chk("R9 mem nack busy", ack, 0); pulse_stop();
        pulse_start(); send(8'h3A); chk("R9 sensor ack busy", ack, 1); pulse_stop();
        hv_pin = 1'b1;
        pulse_start(); send(8'h66); chk("R9 wp nack busy", ack, 0); pulse_stop();
        hv_pin = 1'b0;
        wait_idle();

        // R8 stop after address byte starts nothing
        pulse_start(); send(8'hAA); send(8'h30); pulse_stop();
        chk("R8 no commit", {mem_commit, busy}, 2'b00);

        // R2 protect block 1
        hv_pin = 1'b1;
        pulse_start(); send(8'h68); chk("R2 swp1 ack", ack, 1);
        send(8'h00); send(8'h00); chk("R2 data ack", ack, 1);
        pulse_stop(); chk("R2 busy", {busy, mem_commit}, 2'b10);
        hv_pin = 1'b0; wait_idle();

        // R4 status
        pulse_start(); send(8'h69); chk("R4 protected nack", ack, 0); pulse_stop();
        pulse_start(); send(8'h63); chk("R4 free ack", ack, 1);
        send(8'h00); chk("R4 then nack", {ack_valid, ack}, 2'b10); pulse_stop();

        // R3 repeat set-protect
        hv_pin = 1'b1;
        pulse_start(); send(8'h68); chk("R3 cmd nack", ack, 0);
        send(8'h00); chk("R3 addr nack", ack, 0);
        send(8'h00); chk("R3 data nack", ack, 0);
        pulse_stop(); chk("R3 no cycle", busy, 0);
        hv_pin = 1'b0;

        // R6 protected write refused, counter held
        pulse_start(); send(8'hAA); send(8'h80);
        send(8'h77); chk("R6 nack no we", {ack, mem_we}, 2'b00);
        pulse_start(); send(8'hAB);
        chk("R6 counter held", {rd_strobe, rd_addr}, {1'b1, 9'h080});
        rdone(1'b0); pulse_stop(); chk("R6 no cycle", busy, 0);

        // R5 page 1
        pulse_start(); send(8'h6E); chk("R5 set page1", ack, 1); pulse_stop();
        pulse_start(); send(8'h6D); chk("R5 query page1", ack, 0); pulse_stop();
        pulse_start(); send(8'hAA); send(8'h80);
        send(8'h99); chk("R5 page1 addr", {ack, mem_we, mem_addr}, {2'b11, 9'h180});
        pulse_stop(); wait_idle();

        // R10 sequential read wrap and end
        pulse_start(); send(8'hAA); send(8'hFF);
        pulse_start(); send(8'hAB); chk("R10 first", {rd_strobe, rd_addr}, {1'b1, 9'h1FF});
        rdone(1'b1); chk("R10 wrap", {rd_strobe, rd_addr}, {1'b1, 9'h100});
        rdone(1'b0); chk("R10 nack end", rd_strobe, 0);
        rdone(1'b1); chk("R10 idle", rd_strobe, 0);
        pulse_stop();

        // R2 clear-all
        hv_pin = 1'b1;
        pulse_start(); send(8'h66); chk("R2 cwp ack", ack, 1);
        send(8'h00); send(8'h00); pulse_stop();
        hv_pin = 1'b0; wait_idle();
        pulse_start(); send(8'h69); chk("R2 cleared", ack, 1); pulse_stop();

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule